// File: doc/BRIEF.md
# Serial Command and Data Byte Receiver

This block takes commands and parameters from a host over a write-only serial link and presents each finished byte on the system clock side. The host selects one of two framings with a static mode pin. In the four-wire framing the host drives chip select, serial data, serial clock and a separate data/command line. That line is sampled on the eighth serial clock rise of the frame. In the three-wire framing there is no separate line. Instead a ninth bit leads the frame and carries the data/command flag, followed by the eight payload bits.

The four serial inputs pass through two-flop synchronisers. Serial clock rises are detected in the system clock domain, so the system clock must run at least four times faster than the serial clock. Each completed frame gives one byte, one data/command flag and a single-cycle valid pulse. The byte keeps the same bit order as an 8-bit parallel write, so the result can feed the same downstream path. Raising chip select abandons any partial frame.

Top module: `ser_cmd_rx`

## Requirements
- R1: While reset is asserted and after its release, with no frame sent, `rx_valid` is 0, `rx_byte` is 0x00 and `rx_is_data` is 0.
- R2: With `mode_3w` = 0, eight bits sampled on `sclk` rising edges while `cs_n` is low form `rx_byte`, most significant bit first.
- R3: With `mode_3w` = 0, `rx_is_data` takes the value of `dc_pin` at the eighth `sclk` rise (1 = data, 0 = command). The value of `dc_pin` at the other seven rises has no effect.
- R4: With `mode_3w` = 1, a frame is nine `sclk` rises. The first bit is the flag given on `rx_is_data` (1 = data, 0 = command), and the next eight bits form `rx_byte`, most significant bit first.
- R5: `rx_valid` is high for exactly one clock cycle per completed frame. `rx_byte` and `rx_is_data` change only together with that pulse and hold their values between pulses.
- R6: When `cs_n` goes high, the bit count returns to the start of a frame. A partial frame produces no pulse and does not disturb the next frame.
- R7: `sclk` rises while `cs_n` is high are ignored.
- R8: The pulse for a frame is seen after the third `clk` rising edge that follows the final `sclk` rise, and not before.
- R9: Frames may follow one another with `cs_n` held low, and each produces its own pulse.
- R10: With `mode_3w` = 1, `dc_pin` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_3w | input | 1 | 1 = three-wire framing with in-band flag, 0 = four-wire framing; change only while `cs_n` is high |
| cs_n | input | 1 | Serial chip select, active low, asynchronous |
| sdin | input | 1 | Serial data, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| dc_pin | input | 1 | Data/command line for four-wire framing, asynchronous |
| rx_byte | output | 8 | Received byte |
| rx_is_data | output | 1 | 1 = data/parameter byte, 0 = command byte |
| rx_valid | output | 1 | One-cycle pulse when a frame completes |

## Verification
Each pin change reaches the outputs three clock edges later: two edges pass through the synchroniser, and the output registers add the third. The bench drives every pin shortly after a rising edge and reads the outputs on the falling edge. Its reference model consumes a pin sample taken on each falling edge and keeps its result in a queue. It compares that result with the outputs three falling edges later, which is exactly when the registered response appears. Directed checks add the exact pulse cycle after a final serial rise and the sequence of received bytes and flags for each stimulus pattern.

// File: rtl/ser_cmd_rx.sv
module ser_cmd_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_3w,
  input  logic              cs_n,
  input  logic              sdin,
  input  logic              sclk,
  input  logic              dc_pin,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_is_data,
  output logic              rx_valid
);
  localparam int CW = $clog2(BYTE_W + 2);
  localparam logic [CW-1:0] LAST_4W = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] LAST_3W = CW'(BYTE_W);

  logic [SYNC_STAGES-1:0] cs_sr, sc_sr, sd_sr, dc_sr;
  logic                   sc_prev;
  logic [CW-1:0]          cnt;
  logic [BYTE_W-1:0]      shreg;
  logic                   lead_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr   <= '1;
      sc_sr   <= '0;
      sd_sr   <= '0;
      dc_sr   <= '0;
      sc_prev <= 1'b0;
    end else begin
      cs_sr   <= {cs_sr[SYNC_STAGES-2:0], cs_n};
      sc_sr   <= {sc_sr[SYNC_STAGES-2:0], sclk};
      sd_sr   <= {sd_sr[SYNC_STAGES-2:0], sdin};
      dc_sr   <= {dc_sr[SYNC_STAGES-2:0], dc_pin};
      sc_prev <= sc_sr[SYNC_STAGES-1];
    end
  end

  wire cs_s     = cs_sr[SYNC_STAGES-1];
  wire sc_s     = sc_sr[SYNC_STAGES-1];
  wire sd_s     = sd_sr[SYNC_STAGES-1];
  wire dc_s     = dc_sr[SYNC_STAGES-1];
  wire rise     = sc_s & ~sc_prev & ~cs_s;
  wire [CW-1:0] last_idx = mode_3w ? LAST_3W : LAST_4W;
  wire at_last  = rise && (cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      shreg    <= '0;
      lead_bit <= 1'b0;
    end else if (cs_s) begin
      cnt <= '0;
    end else if (rise) begin
      cnt   <= at_last ? '0 : cnt + 1'b1;
      shreg <= {shreg[BYTE_W-2:0], sd_s};
      if (cnt == '0) lead_bit <= sd_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte    <= '0;
      rx_is_data <= 1'b0;
      rx_valid   <= 1'b0;
    end else begin
      rx_valid <= at_last;
      if (at_last) begin
        rx_byte    <= {shreg[BYTE_W-2:0], sd_s};
        rx_is_data <= mode_3w ? lead_bit : dc_s;
      end
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R5
  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rx_byte) |-> rx_valid); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rx_is_data) |-> rx_valid); // R5
  AST_CS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) cs_s |=> cnt == '0); // R6
  AST_NO_VLD_CS: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> !$past(cs_s)); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST_3W); // R4
endmodule

// File: tb/ser_cmd_rx_tb.sv
module ser_cmd_rx_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic clk = 0, rst_n = 0, mode_3w = 0, cs_n = 1, sdin = 0, sclk = 0, dc_pin = 0;
  logic [7:0] rx_byte;
  logic rx_is_data, rx_valid;

  int errors = 0, checks = 0;
  string phase = "R1";
  bit done = 0;

  logic [9:0] exp_q[$];
  logic [8:0] got_q[$];
  int m_cnt = 0, m_psc = 0, m_lead = 0, m_vld = 0, m_flag = 0;
  logic [7:0] m_sh = 0, m_byte = 0;

  ser_cmd_rx u_dut (.clk(clk), .rst_n(rst_n), .mode_3w(mode_3w), .cs_n(cs_n), .sdin(sdin),
    .sclk(sclk), .dc_pin(dc_pin), .rx_byte(rx_byte), .rx_is_data(rx_is_data), .rx_valid(rx_valid));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      exp_q = {10'h0, 10'h0, 10'h0};
      m_cnt = 0; m_psc = 0; m_vld = 0; m_flag = 0; m_sh = 0; m_byte = 0;
    end else begin
      m_vld = 0;
      if (cs_n) m_cnt = 0;
      else if (sclk && m_psc == 0) begin
        m_sh = {m_sh[6:0], sdin};
        if (m_cnt == 0) m_lead = sdin;
        if (m_cnt == (mode_3w ? 8 : 7)) begin
          m_vld = 1; m_byte = m_sh; m_flag = mode_3w ? m_lead : dc_pin; m_cnt = 0;
        end else m_cnt++;
      end
      m_psc = sclk;
      exp_q.push_back({m_vld[0], m_flag[0], m_byte});
      begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk({phase, "/R5 valid"}, rx_valid, e[9]);
        chk({phase, "/R5 flag"}, rx_is_data, e[8]);
        chk({phase, "/R5 byte"}, rx_byte, e[7:0]);
      end
      if (rx_valid) got_q.push_back({rx_is_data, rx_byte});
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_bit(bit b, bit a0);
    tick(1); sclk = 0; sdin = b; dc_pin = a0;
    tick(HALF); sclk = 1;
    tick(HALF);
  endtask

  task automatic frame4(logic [7:0] v, bit a0);
    for (int i = 7; i >= 0; i--) send_bit(v[i], (i == 0) ? a0 : ~a0);
  endtask

  task automatic frame3(logic [7:0] v, bit f);
    send_bit(f, 0);
    for (int i = 7; i >= 0; i--) send_bit(v[i], i[0]);
  endtask

  task automatic cs_low();  tick(1); cs_n = 0; sclk = 0; tick(HALF); endtask
  task automatic cs_high(); tick(HALF); sclk = 0; cs_n = 1; tick(HALF + 4); endtask

  task automatic expect_rx(string req, bit f, logic [7:0] v);
    logic [8:0] g;
    checks++;
    if (got_q.size() == 0) begin
      errors++;
      $display("FAIL %s: actual=none expected=%0h", req, {f, v});
      return;
    end
    g = got_q.pop_front();
    if (g != {f, v}) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, g, {f, v});
    end
  endtask

  task automatic expect_empty(string req);
    chk(req, got_q.size(), 0);
    got_q.delete();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 valid in reset", rx_valid, 0);
    chk("R1 byte in reset", rx_byte, 0);
    rst_n = 1;
    tick(5);
    chk("R1 valid", rx_valid, 0);
    chk("R1 byte", rx_byte, 0);
    chk("R1 flag", rx_is_data, 0);

    phase = "R2";
    cs_low(); frame4(8'hA5, 1); cs_high();
    expect_rx("R2 data byte", 1, 8'hA5);
    phase = "R3";
    cs_low(); frame4(8'h3C, 0); cs_high();
    expect_rx("R3 command byte", 0, 8'h3C);

    phase = "R8";
    cs_low();
    for (int i = 7; i >= 1; i--) send_bit(i[0], 1);
    tick(1); sclk = 0; sdin = 1; dc_pin = 1;
    tick(HALF); sclk = 1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk("R8 pulse cycle", rx_valid, (k == 4) ? 1 : 0);
    end
    tick(HALF); cs_high();
    expect_rx("R8 byte", 1, 8'hAB);

    phase = "R6";
    cs_low();
    for (int i = 0; i < 5; i++) send_bit(1, 1);
    cs_high();
    expect_empty("R6 partial frame no pulse");
    cs_low(); frame4(8'h81, 1); cs_high();
    expect_rx("R6 next frame intact", 1, 8'h81);

    phase = "R7";
    for (int i = 0; i < 10; i++) send_bit(i[0], 1);
    tick(8);
    expect_empty("R7 sclk with cs high");
    cs_low(); frame4(8'h42, 0); cs_high();
    expect_rx("R7 frame after", 0, 8'h42);

    phase = "R9";
    cs_low(); frame4(8'h11, 1); frame4(8'hEE, 0); frame4(8'h7F, 1); cs_high();
    expect_rx("R9 first", 1, 8'h11);
    expect_rx("R9 second", 0, 8'hEE);
    expect_rx("R9 third", 1, 8'h7F);

    mode_3w = 1;
    phase = "R4";
    cs_low(); frame3(8'h96, 1); cs_high();
    expect_rx("R4 data frame", 1, 8'h96);
    cs_low(); frame3(8'h5A, 0); cs_high();
    expect_rx("R4 command frame", 0, 8'h5A);
    phase = "R10";
    cs_low();
    send_bit(0, 1);
    for (int i = 7; i >= 0; i--) send_bit(i < 4, 1);
    send_bit(1, 0);
    for (int i = 7; i >= 0; i--) send_bit(i >= 4, 0);
    cs_high();
    expect_rx("R10 dc ignored cmd", 0, 8'h0F);
    expect_rx("R10 dc ignored data", 1, 8'hF0);
    phase = "R6";
    cs_low();
    for (int i = 0; i < 8; i++) send_bit(1, 1);
    cs_high();
    expect_empty("R6 three-wire partial");
    cs_low(); frame3(8'hC3, 0); cs_high();
    expect_rx("R6 three-wire after partial", 0, 8'hC3);

    tick(6);
    expect_empty("R5 no extra pulses");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule